// File: doc/BRIEF.md
# Watchdog Timer with Sleep Wake-Up

This block is a 16-bit up-counting watchdog for a CPU subsystem. A free-running prescaler divides the clock, and each prescaler tick advances the count while the watchdog is enabled. Software services the watchdog by strobing a reload byte. The byte becomes the upper part of the count, and the lower part is cleared. If the count wraps past its all-ones value before the next service, the block pulses a reset request and sets sticky status flags.

The same counter paces a sleeping CPU. While the CPU reports idle or sleep and the watchdog is enabled, the most significant bit of the count rising from 0 to 1 produces a one-cycle wake-up pulse. The reload byte therefore sets the wake-up interval. If debugging was enabled at the last reset, a debug suspend input freezes the count.

A timeout that follows an earlier timeout, with no service between them, is treated as a double error. In that case the block raises a latched system-halt output instead of issuing another reset. Only power-on reset clears the halt.

Top module: `wdsw_top`

## Requirements
- R1: After power-on reset the count is 0x0000 and the outputs err_o, first_o, rst_req_o, wake_o and halt_o are all 0.
- R2: A service strobe loads the count with {svc_val, 8'h00}, visible in the cycle after the strobe edge; a service takes priority over a tick in the same cycle.
- R3: While enabled, not halted and not suspended, the count rises by exactly one per 2^PRESC_W clock cycles.
- R4: With cpu_sleep high and the watchdog enabled, the count stepping from 0x7FFF to 0x8000 gives a one-cycle wake_o pulse, in the same cycle the count reads 0x8000; with cpu_sleep low no pulse occurs.
- R5: With wdg_en low the count holds its value and neither wake_o nor rst_req_o is pulsed.
- R6: The first wake-up after a service with reload R comes after 0x8000 - R*256 ticks, so the longest interval (R = 0, 32768 ticks) is half the longest timeout (65536 ticks).
- R7: A tick at count 0xFFFF with first_o low gives a one-cycle rst_req_o pulse, sets err_o and first_o, and restarts the count at {last reload, 8'h00}.
- R8: A service clears first_o, so the next timeout again produces a reset request.
- R9: A timeout while first_o is high sets halt_o and gives no rst_req_o pulse; while halted the count is frozen, and only power-on reset clears halt_o (sw_rst does not).
- R10: dbg_en is sampled during power-on reset or sw_rst; if it was high, dbg_susp high freezes the count and releasing it resumes counting; if it was low, dbg_susp is ignored.
- R11: sw_rst clears err_o and leaves first_o unchanged; a watchdog timeout keeps err_o set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Synchronous active-high power-on reset |
| wdg_en | input | 1 | Watchdog enable |
| svc_stb | input | 1 | Service strobe, one cycle |
| svc_val | input | RLD_W | Reload byte used on service |
| cpu_sleep | input | 1 | CPU is idle or asleep |
| dbg_en | input | 1 | Debug enable, sampled at reset |
| dbg_susp | input | 1 | Debug suspend request |
| sw_rst | input | 1 | Software reset indication |
| cnt_o | output | CNT_W | Current count |
| err_o | output | 1 | Sticky timeout error flag |
| first_o | output | 1 | A watchdog reset has occurred since the last service |
| rst_req_o | output | 1 | Reset request pulse |
| wake_o | output | 1 | Wake-up pulse |
| halt_o | output | 1 | Latched system halt |

## Verification
The wake-up path is tried with a sleeping CPU, an awake CPU and a disabled watchdog. This separates the effect of the MSB edge from the sleep gate and from the enable gate. The interval is measured for reload 0x7E and for reload 0x00. The second case confirms that the longest wake-up spacing is half the longest timeout. Timeouts are driven once after a service and twice without one, which separates a plain reset request from the latched halt. A suspend is applied with debug sampled low and then with it sampled high, to show that the freeze depends on the value taken at reset.

// File: rtl/wdsw_pkg.sv
package wdsw_pkg;
  typedef struct packed {
    logic wrap;   // tick taken at all-ones count
    logic wake;   // registered wake-up pulse
  } wdsw_evt_t;
endpackage

// File: rtl/wdsw_presc.sv
module wdsw_presc #(
  parameter int PRESC_W = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam logic [PRESC_W-1:0] DIV_LAST = {PRESC_W{1'b1}};

  logic [PRESC_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == DIV_LAST);

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdsw_counter.sv
module wdsw_counter
  import wdsw_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int RLD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             svc_i,
  input  logic [RLD_W-1:0] svc_val_i,
  input  logic             sleep_i,
  output logic [CNT_W-1:0] cnt_o,
  output wdsw_evt_t        evt_o
);
  localparam int               LOW_W  = CNT_W - RLD_W;
  localparam logic [CNT_W-1:0] ALL1   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] HALF_M = {1'b0, {(CNT_W-1){1'b1}}};

  logic [CNT_W-1:0] cnt_q;
  logic [RLD_W-1:0] rld_q;
  logic             wake_q;
  logic             step;
  logic             at_top;

  assign step   = tick_i & run_i & ~svc_i;
  assign at_top = (cnt_q == ALL1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= step & sleep_i & (cnt_q == HALF_M);
      if (svc_i) begin
        cnt_q <= {svc_val_i, {LOW_W{1'b0}}};
        rld_q <= svc_val_i;
      end else if (step) begin
        if (at_top) cnt_q <= {rld_q, {LOW_W{1'b0}}};
        else        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o      = cnt_q;
  assign evt_o.wrap = step & at_top;
  assign evt_o.wake = wake_q;

  // R2
  svc_load_chk: assert property (@(posedge clk) disable iff (rst)
    svc_i |=> (cnt_q == {$past(svc_val_i), {LOW_W{1'b0}}}));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !svc_i) |=> $stable(cnt_q));
  // R4
  wake_msb_chk: assert property (@(posedge clk) disable iff (rst)
    wake_q |-> (cnt_q[CNT_W-1] && cnt_q[CNT_W-2:0] == '0));
  // R4
  wake_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wake_q |=> !wake_q);
endmodule

// File: rtl/wdsw_guard.sv
module wdsw_guard (
  input  logic clk,
  input  logic rst,
  input  logic wrap_i,
  input  logic svc_i,
  input  logic sw_rst_i,
  input  logic en_i,
  input  logic dbg_en_i,
  input  logic dbg_susp_i,
  output logic run_o,
  output logic rst_req_o,
  output logic err_o,
  output logic first_o,
  output logic halt_o
);
  logic dbg_arm_q;
  logic rst_req_q;
  logic err_q;
  logic first_q;
  logic halt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_arm_q <= dbg_en_i;
      rst_req_q <= 1'b0;
      err_q     <= 1'b0;
      first_q   <= 1'b0;
      halt_q    <= 1'b0;
    end else begin
      if (sw_rst_i) dbg_arm_q <= dbg_en_i;
      rst_req_q <= wrap_i & ~first_q;
      if (wrap_i & first_q) halt_q <= 1'b1;
      if (wrap_i)     first_q <= 1'b1;
      else if (svc_i) first_q <= 1'b0;
      if (wrap_i)        err_q <= 1'b1;
      else if (sw_rst_i) err_q <= 1'b0;
    end
  end

  assign run_o     = en_i & ~halt_q & ~(dbg_arm_q & dbg_susp_i);
  assign rst_req_o = rst_req_q;
  assign err_o     = err_q;
  assign first_o   = first_q;
  assign halt_o    = halt_q;

  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req_q |=> !rst_req_q);
  // R7
  rst_flags_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req_q |-> (err_q && first_q));
  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> halt_q);
  // R9
  halt_no_rst_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_q) |-> !rst_req_q);
  // R8
  svc_first_chk: assert property (@(posedge clk) disable iff (rst)
    (svc_i && !wrap_i) |=> !first_q);
endmodule

// File: rtl/wdsw_top.sv
module wdsw_top
  import wdsw_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RLD_W   = 8,
  parameter int PRESC_W = 8
) (
  input  logic             clk,
  input  logic             rst_por,
  input  logic             wdg_en,
  input  logic             svc_stb,
  input  logic [RLD_W-1:0] svc_val,
  input  logic             cpu_sleep,
  input  logic             dbg_en,
  input  logic             dbg_susp,
  input  logic             sw_rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             err_o,
  output logic             first_o,
  output logic             rst_req_o,
  output logic             wake_o,
  output logic             halt_o
);
  logic      tick;
  logic      run;
  wdsw_evt_t evt;

  wdsw_presc #(.PRESC_W(PRESC_W)) u_presc (
    .clk    (clk),
    .rst    (rst_por),
    .tick_o (tick)
  );

  wdsw_counter #(.CNT_W(CNT_W), .RLD_W(RLD_W)) u_cnt (
    .clk       (clk),
    .rst       (rst_por),
    .tick_i    (tick),
    .run_i     (run),
    .svc_i     (svc_stb),
    .svc_val_i (svc_val),
    .sleep_i   (cpu_sleep),
    .cnt_o     (cnt_o),
    .evt_o     (evt)
  );

  wdsw_guard u_guard (
    .clk        (clk),
    .rst        (rst_por),
    .wrap_i     (evt.wrap),
    .svc_i      (svc_stb),
    .sw_rst_i   (sw_rst),
    .en_i       (wdg_en),
    .dbg_en_i   (dbg_en),
    .dbg_susp_i (dbg_susp),
    .run_o      (run),
    .rst_req_o  (rst_req_o),
    .err_o      (err_o),
    .first_o    (first_o),
    .halt_o     (halt_o)
  );

  assign wake_o = evt.wake;

  // R5
  dis_quiet_chk: assert property (@(posedge clk) disable iff (rst_por)
    !wdg_en |=> !(wake_o || rst_req_o));
endmodule

// File: tb/test_wdsw_top.sv
module test_wdsw_top;
  localparam int PW  = 1;
  localparam int DIV = 1 << PW;

  logic        clk = 1'b0;
  logic        rst_por, wdg_en, svc_stb, cpu_sleep, dbg_en, dbg_susp, sw_rst;
  logic [7:0]  svc_val;
  logic [15:0] cnt_o;
  logic        err_o, first_o, rst_req_o, wake_o, halt_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  wdsw_top #(.CNT_W(16), .RLD_W(8), .PRESC_W(PW)) i_wdsw_top (
    .clk(clk), .rst_por(rst_por), .wdg_en(wdg_en), .svc_stb(svc_stb),
    .svc_val(svc_val), .cpu_sleep(cpu_sleep), .dbg_en(dbg_en),
    .dbg_susp(dbg_susp), .sw_rst(sw_rst), .cnt_o(cnt_o), .err_o(err_o),
    .first_o(first_o), .rst_req_o(rst_req_o), .wake_o(wake_o), .halt_o(halt_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic por(input logic dbg);
    @(negedge clk);
    rst_por = 1'b1; dbg_en = dbg;
    repeat (3) @(negedge clk);
    rst_por = 1'b0;
  endtask

  task automatic service(input logic [7:0] v);
    @(negedge clk);
    svc_stb = 1'b1; svc_val = v;
    @(negedge clk);
    svc_stb = 1'b0;
  endtask

  // sel: 0 wake, 1 reset request, 2 halt; counts edges until seen
  task automatic wait_out(input int sel, input int lim, output int d, output int rst_seen);
    d = 0; rst_seen = 0;
    while (d < lim) begin
      @(posedge clk); d++;
      @(negedge clk);
      if (rst_req_o) rst_seen++;
      if ((sel == 0 && wake_o) || (sel == 1 && rst_req_o) || (sel == 2 && halt_o)) break;
    end
  endtask

  task automatic t_reset();
    por(1'b0);
    // R1
    chk("R1 cnt", cnt_o, 0);
    chk("R1 flags", {err_o, first_o, rst_req_o, wake_o, halt_o}, 0);
  endtask

  task automatic t_count();
    service(8'h12);
    chk("R2 load", cnt_o, 16'h1200);
    repeat (20) @(negedge clk);
    chk("R3 rate", cnt_o, 16'h1200 + 20 / DIV);
  endtask

  task automatic t_wake_awake();
    int d, r;
    cpu_sleep = 1'b0;
    service(8'h7F);
    wait_out(0, 700, d, r);
    chk("R4 no wake awake", wake_o, 0);
    chk("R4 msb passed", cnt_o[15], 1);
  endtask

  task automatic t_wake_sleep();
    int d, r;
    cpu_sleep = 1'b1;
    service(8'h7E);
    wait_out(0, 1200, d, r);
    chk("R4 wake seen", wake_o, 1);
    chk("R4 cnt at wake", cnt_o, 16'h8000);
    chk_rng("R6 interval 7E", d, 511 * DIV + 1, 512 * DIV);
    @(negedge clk);
    chk("R4 one cycle", wake_o, 0);
  endtask

  task automatic t_wake_max();
    int d, r;
    service(8'h00);
    wait_out(0, 70000, d, r);
    chk("R6 wake max seen", wake_o, 1);
    chk_rng("R6 interval max", d, 32767 * DIV + 1, 32768 * DIV);
    service(8'hFF);
  endtask

  task automatic t_disabled();
    int d, r;
    wdg_en = 1'b0;
    service(8'h7F);
    wait_out(0, 1200, d, r);
    chk("R5 no wake", wake_o, 0);
    chk("R5 no rst", r, 0);
    chk("R5 hold", cnt_o, 16'h7F00);
    wdg_en = 1'b1;
    cpu_sleep = 1'b0;
  endtask

  task automatic t_timeout();
    int d, r;
    service(8'hFF);
    wait_out(1, 1000, d, r);
    chk("R7 rst seen", rst_req_o, 1);
    chk_rng("R7 delay", d, 255 * DIV + 1, 256 * DIV);
    chk("R7 restart", cnt_o, 16'hFF00);
    chk("R7 flags", {err_o, first_o, halt_o}, 3'b110);
    @(negedge clk);
    chk("R7 one cycle", rst_req_o, 0);
    chk("R11 err kept", err_o, 1);
  endtask

  task automatic t_svc_clears();
    int d, r;
    service(8'hFF);
    chk("R8 first cleared", first_o, 0);
    wait_out(1, 1000, d, r);
    chk("R8 rst again", rst_req_o, 1);
    chk("R8 halt low", halt_o, 0);
  endtask

  task automatic t_swrst();
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk); sw_rst = 1'b0;
    chk("R11 err cleared", err_o, 0);
    chk("R11 first kept", first_o, 1);
  endtask

  task automatic t_halt();
    int d, r;
    logic [15:0] snap;
    wait_out(2, 1000, d, r);
    chk("R9 halt set", halt_o, 1);
    chk("R9 no rst", r, 0);
    chk("R9 err set", err_o, 1);
    snap = cnt_o;
    repeat (40) @(negedge clk);
    chk("R9 frozen", cnt_o, snap);
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk); sw_rst = 1'b0;
    chk("R9 swrst keeps halt", halt_o, 1);
    por(1'b0);
    chk("R9 por clears", {halt_o, first_o}, 0);
  endtask

  task automatic t_debug();
    logic [15:0] snap;
    service(8'h10);
    dbg_susp = 1'b1;
    repeat (20) @(negedge clk);
    chk("R10 ignored", cnt_o, 16'h1000 + 20 / DIV);
    dbg_susp = 1'b0;
    por(1'b1);
    dbg_en = 1'b0;
    service(8'h10);
    dbg_susp = 1'b1;
    snap = cnt_o;
    repeat (40) @(negedge clk);
    chk("R10 frozen", cnt_o, snap);
    dbg_susp = 1'b0;
    snap = cnt_o;
    repeat (20) @(negedge clk);
    chk("R10 resumes", cnt_o, snap + 20 / DIV);
  endtask

  initial begin
    rst_por = 1'b1; wdg_en = 1'b1; svc_stb = 1'b0; svc_val = '0;
    cpu_sleep = 1'b0; dbg_en = 1'b0; dbg_susp = 1'b0; sw_rst = 1'b0;
    t_reset();
    t_count();
    t_wake_awake();
    t_wake_sleep();
    t_wake_max();
    t_disabled();
    t_timeout();
    t_svc_clears();
    t_swrst();
    t_halt();
    t_debug();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule